// File: doc/BRIEF.md
# Control-Word Driven 16-bit ALU

This block is the arithmetic and logic unit that sits behind an instruction decoder in a small 16-bit processor. It is purely combinational. The decoder presents a 12-bit control word in which each bit switches on one piece of hardware: a source inverter, an increment source, one of five result paths, and one of three status-update policies. A separate pair of inputs selects a one-bit right rotate through carry or a one-bit arithmetic right shift. No opcode is decoded inside the block. Each instruction is the set of control bits the decoder raises.

Each cycle the block takes a source operand, a destination operand, the incoming carry, a byte/word select and the current status flags. It returns the result, the next status flags, a mask that shows which flags the operation updated, and a write-enable for the destination. The register file, status register storage, instruction decoding and memory access all sit outside the block.

Top module: `ctl_alu`

## Requirements
- R1: Control word `ctl_i` bits are: 0 invert source, 1 force increment of 1, 2 increment by `carry_i`, 3 adder, 4 AND, 5 OR, 6 XOR, 7 decimal add, 8 flag policy N/Z/C with C = NOT Z, 9 update all flags, 10 XOR flag policy, 11 suppress write. With bit 3 set, the result is destination + operand + increment. The operand is the source, inverted when bit 0 is set. The increment is 1 when bit 1 is set, else `carry_i` when bit 2 is set, else 0. Add with bits 3 and 9 (0x208) ignores `carry_i`. Add-with-carry is 0x20C.
- R2: Subtract (0x20B), subtract-with-carry (0x20D) and compare (0xA0B) use the inverted source. After the operation, C = 1 means no borrow occurred.
- R3: `wr_en_o` is the inverse of control bit 11. Compare and bit-test (0xB10) leave it low, and every other operation raises it.
- R4: For the adder, V is set when the destination and the (possibly inverted) operand have the same sign and the result sign differs from it. C is the carry out of the top bit of the active width.
- R5: With control bit 8 set (AND 0x310, bit-test 0xB10), C equals NOT Z.
- R6: Decimal add (0x284) adds two packed-BCD operands plus `carry_i`. It adds 6 to every nibble whose sum exceeds 9. C is the carry out of the top nibble of the active width, and V is 0.
- R7: Flags are packed as bit 0 C, bit 1 Z, bit 2 N, bit 3 V. `upd_o` is 4'hF when control bit 9, bit 10 or the shift enable is set. It is 4'h7 when only bit 8 is set among these, and 4'h0 otherwise (bit-clear 0x011, bit-set 0x020). Every flag whose mask bit is 0 equals the corresponding bit of `flags_prev_i`. N is the top bit of the result and Z is set when the result is zero.
- R8: XOR (0x640) gives V = 1 when both operands are negative and C = NOT Z.
- R9: With `shr_en_i` set, the source moves right by one bit. The top bit is filled with `carry_i` (rotate) or with the old top bit when `shr_arith_i` is set (arithmetic shift). C is the old bit 0, V is 0, and all flags update.
- R10: With `byte_i` set, only bits 7:0 of the operands take part. N, C, V and Z refer to bit 7 and the low byte, and result bits 15:8 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_i | input | 12 | Control word from the decoder |
| shr_en_i | input | 1 | Enable one-bit right shift of the source |
| shr_arith_i | input | 1 | 1: arithmetic shift, 0: rotate through carry |
| byte_i | input | 1 | Byte-width operation |
| carry_i | input | 1 | Incoming carry flag |
| flags_prev_i | input | 4 | Current flags {V,N,Z,C} |
| src_i | input | W | Source operand |
| dst_i | input | W | Destination operand |
| res_o | output | W | Result |
| flags_o | output | 4 | Next flags {V,N,Z,C} |
| upd_o | output | 4 | Flags updated by this operation |
| wr_en_o | output | 1 | Destination write enable |

## Verification
The bench builds the block with its defaults: W = 16 and a byte lane of 8. This gives a four-nibble decimal carry chain in word mode and a two-nibble chain in byte mode. The carry and sign taps sit at bits 15 and 7. The vectors check that a carry leaving nibble 1 in byte mode sets C but never shows in bits 15:8. They also check that junk in the upper source and destination bytes has no effect, and that the overflow cases are hit at both widths.

// File: rtl/ctl_alu.sv
module ctl_alu #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic [11:0]  ctl_i,
  input  logic         shr_en_i,
  input  logic         shr_arith_i,
  input  logic         byte_i,
  input  logic         carry_i,
  input  logic [3:0]   flags_prev_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  output logic [W-1:0] res_o,
  output logic [3:0]   flags_o,
  output logic [3:0]   upd_o,
  output logic         wr_en_o
);
  localparam int NIB  = W / 4;
  localparam int BNIB = BW / 4;
  localparam logic [W-1:0] BYTE_MASK = {{(W-BW){1'b0}}, {BW{1'b1}}};

  logic [W-1:0] lane, a, b, s, sh, dec, raw;
  logic [W:0]   sum;
  logic         cin, add_co, dec_co, msb_in;
  logic         a_n, b_n, r_n, z, c_new, v_new;
  logic [3:0]   fl_new;

  assign lane = byte_i ? BYTE_MASK : {W{1'b1}};
  assign a    = dst_i & lane;
  assign b    = (ctl_i[0] ? ~src_i : src_i) & lane;
  assign s    = src_i & lane;
  assign cin  = ctl_i[1] | (ctl_i[2] & carry_i);

  assign sum    = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign add_co = byte_i ? sum[BW] : sum[W];

  always_comb begin
    logic       c;
    logic [4:0] t;
    c      = cin;
    dec    = '0;
    dec_co = 1'b0;
    for (int k = 0; k < NIB; k++) begin
      t = {1'b0, a[4*k +: 4]} + {1'b0, b[4*k +: 4]} + {4'b0, c};
      if (t > 5'd9) begin
        t = t + 5'd6;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      dec[4*k +: 4] = t[3:0];
      if ((byte_i && k == BNIB-1) || (!byte_i && k == NIB-1))
        dec_co = c;
    end
  end

  assign msb_in = shr_arith_i ? (byte_i ? s[BW-1] : s[W-1]) : carry_i;

  always_comb begin
    sh = s >> 1;
    if (byte_i) sh[BW-1] = msb_in;
    else        sh[W-1]  = msb_in;
  end

  assign raw = ({W{ctl_i[3]}} & sum[W-1:0])
             | ({W{ctl_i[4]}} & (a & b))
             | ({W{ctl_i[5]}} & (a | b))
             | ({W{ctl_i[6]}} & (a ^ b))
             | ({W{ctl_i[7]}} & dec)
             | ({W{shr_en_i}} & sh);
  assign res_o = raw & lane;

  assign a_n = byte_i ? a[BW-1]     : a[W-1];
  assign b_n = byte_i ? b[BW-1]     : b[W-1];
  assign r_n = byte_i ? res_o[BW-1] : res_o[W-1];
  assign z   = (res_o == '0);

  always_comb begin
    if (shr_en_i)                 c_new = s[0];
    else if (ctl_i[8] | ctl_i[10]) c_new = ~z;
    else if (ctl_i[7])            c_new = dec_co;
    else if (ctl_i[3])            c_new = add_co;
    else                          c_new = 1'b0;

    if (shr_en_i)       v_new = 1'b0;
    else if (ctl_i[10]) v_new = a_n & b_n;
    else if (ctl_i[3])  v_new = (a_n == b_n) & (r_n != a_n);
    else                v_new = 1'b0;
  end

  assign fl_new  = {v_new, r_n, z, c_new};
  assign upd_o   = (ctl_i[9] | ctl_i[10] | shr_en_i) ? 4'hF :
                   ctl_i[8] ? 4'h7 : 4'h0;
  assign flags_o = (upd_o & fl_new) | (~upd_o & flags_prev_i);
  assign wr_en_o = ~ctl_i[11];
endmodule

// File: rtl/ctl_alu_chk.sv
module ctl_alu_chk #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input logic [11:0]  ctl_i,
  input logic         shr_en_i,
  input logic         byte_i,
  input logic [3:0]   flags_prev_i,
  input logic [W-1:0] res_o,
  input logic [3:0]   flags_o,
  input logic [3:0]   upd_o,
  input logic         wr_en_o
);
  logic known;
  assign known = !$isunknown({ctl_i, shr_en_i, byte_i, flags_prev_i, res_o, flags_o, upd_o, wr_en_o});

  always_comb begin
    if (known) begin
      a_r3_write_gate: assert (wr_en_o == !ctl_i[11]);
      a_r10_upper_clear: assert (!byte_i || res_o[W-1:BW] == '0);
      a_r7_hold_prev: assert (((flags_o ^ flags_prev_i) & ~upd_o) == 4'h0);
      a_r7_zero_flag: assert (!upd_o[1] ||
        flags_o[1] == (byte_i ? (res_o[BW-1:0] == '0) : (res_o == '0)));
      a_r5_c_not_z: assert (!(ctl_i[8] && !shr_en_i && upd_o[0]) || (flags_o[0] == !flags_o[1]));
    end
  end
endmodule

bind ctl_alu ctl_alu_chk #(.W(W), .BW(BW)) u_chk (
  .ctl_i(ctl_i), .shr_en_i(shr_en_i), .byte_i(byte_i), .flags_prev_i(flags_prev_i),
  .res_o(res_o), .flags_o(flags_o), .upd_o(upd_o), .wr_en_o(wr_en_o)
);

// File: tb/tb_ctl_alu.sv
module tb_ctl_alu;
  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [11:0] ctl;
  logic        shr_en, shr_ar, byt, cin;
  logic [3:0]  prev;
  logic [15:0] src, dst, res;
  logic [3:0]  flg, upd;
  logic        wr;

  ctl_alu dut (
    .ctl_i(ctl), .shr_en_i(shr_en), .shr_arith_i(shr_ar), .byte_i(byt), .carry_i(cin),
    .flags_prev_i(prev), .src_i(src), .dst_i(dst),
    .res_o(res), .flags_o(flg), .upd_o(upd), .wr_en_o(wr)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [11:0] ctl;
    logic        sh, ar, by, ci;
    logic [3:0]  prev;
    logic [15:0] src, dst, res;
    logic [3:0]  flg, upd;
    logic        wr;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{8'd1,  12'h208, 1'b0,1'b0,1'b0,1'b1, 4'h0, 16'h0001, 16'h1234, 16'h1235, 4'h0, 4'hF, 1'b1}, // R1 add ignores carry
    '{8'd4,  12'h208, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0001, 16'h7FFF, 16'h8000, 4'hC, 4'hF, 1'b1}, // R4
    '{8'd4,  12'h208, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0001, 16'hFFFF, 16'h0000, 4'h3, 4'hF, 1'b1}, // R4 carry out
    '{8'd1,  12'h20C, 1'b0,1'b0,1'b0,1'b1, 4'h0, 16'h0001, 16'h0001, 16'h0003, 4'h0, 4'hF, 1'b1}, // R1 addc
    '{8'd2,  12'h20B, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0003, 16'h0005, 16'h0002, 4'h1, 4'hF, 1'b1}, // R2
    '{8'd2,  12'h20B, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0005, 16'h0003, 16'hFFFE, 4'h4, 4'hF, 1'b1}, // R2 borrow
    '{8'd3,  12'hA0B, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0005, 16'h0005, 16'h0000, 4'h3, 4'hF, 1'b0}, // R3 cmp
    '{8'd2,  12'h20D, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0003, 16'h0005, 16'h0001, 4'h1, 4'hF, 1'b1}, // R2 subc
    '{8'd4,  12'h20B, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0001, 16'h8000, 16'h7FFF, 4'h9, 4'hF, 1'b1}, // R4 sub ovf
    '{8'd6,  12'h284, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0001, 16'h0199, 16'h0200, 4'h0, 4'hF, 1'b1}, // R6
    '{8'd6,  12'h284, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0001, 16'h9999, 16'h0000, 4'h3, 4'hF, 1'b1}, // R6 carry
    '{8'd6,  12'h284, 1'b0,1'b0,1'b0,1'b1, 4'h0, 16'h0054, 16'h0045, 16'h0100, 4'h0, 4'hF, 1'b1}, // R6 carry in
    '{8'd5,  12'h310, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h00FF, 16'h0F0F, 16'h000F, 4'h1, 4'hF, 1'b1}, // R5 and
    '{8'd5,  12'hB10, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0F00, 16'hF000, 16'h0000, 4'h2, 4'hF, 1'b0}, // R5 R3 bit
    '{8'd7,  12'h011, 1'b0,1'b0,1'b0,1'b0, 4'hA, 16'h00F0, 16'hFFFF, 16'hFF0F, 4'hA, 4'h0, 1'b1}, // R7 bic
    '{8'd7,  12'h020, 1'b0,1'b0,1'b0,1'b0, 4'h5, 16'h0034, 16'h1200, 16'h1234, 4'h5, 4'h0, 1'b1}, // R7 bis
    '{8'd8,  12'h640, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h8003, 16'h8001, 16'h0002, 4'h9, 4'hF, 1'b1}, // R8
    '{8'd8,  12'h640, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h00FF, 16'h00FF, 16'h0000, 4'h2, 4'hF, 1'b1}, // R8 zero
    '{8'd9,  12'h000, 1'b1,1'b0,1'b0,1'b1, 4'h0, 16'h0003, 16'hFFFF, 16'h8001, 4'h5, 4'hF, 1'b1}, // R9 rotate
    '{8'd9,  12'h000, 1'b1,1'b1,1'b0,1'b1, 4'h0, 16'h8004, 16'h0000, 16'hC002, 4'h4, 4'hF, 1'b1}, // R9 arith
    '{8'd10, 12'h208, 1'b0,1'b0,1'b1,1'b0, 4'h0, 16'h12FF, 16'h3401, 16'h0000, 4'h3, 4'hF, 1'b1}, // R10 add
    '{8'd10, 12'h208, 1'b0,1'b0,1'b1,1'b0, 4'h0, 16'hAA7F, 16'h5501, 16'h0080, 4'hC, 4'hF, 1'b1}, // R10 ovf
    '{8'd10, 12'h284, 1'b0,1'b0,1'b1,1'b0, 4'h0, 16'h3401, 16'h1299, 16'h0000, 4'h3, 4'hF, 1'b1}, // R10 dadd
    '{8'd10, 12'h000, 1'b1,1'b0,1'b1,1'b1, 4'h0, 16'hFF02, 16'h0000, 16'h0081, 4'h4, 4'hF, 1'b1}, // R10 rotate
    '{8'd10, 12'h000, 1'b1,1'b1,1'b1,1'b0, 4'h0, 16'h0081, 16'h0000, 16'h00C0, 4'h5, 4'hF, 1'b1}, // R10 arith
    '{8'd10, 12'h640, 1'b0,1'b0,1'b1,1'b0, 4'h0, 16'h0080, 16'h0080, 16'h0000, 4'hA, 4'hF, 1'b1}, // R10 xor
    '{8'd10, 12'h310, 1'b0,1'b0,1'b1,1'b0, 4'h0, 16'hFFFF, 16'hFF00, 16'h0000, 4'h2, 4'hF, 1'b1}  // R10 and
  };

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input int r, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(posedge clk);
    ctl = v.ctl; shr_en = v.sh; shr_ar = v.ar; byt = v.by; cin = v.ci;
    prev = v.prev; src = v.src; dst = v.dst;
    @(negedge clk);
  endtask

  task automatic run(input vec_t v);
    drive(v);
    chk(int'(v.req), "result", res, v.res);
    chk(int'(v.req), "flags", {12'h0, flg}, {12'h0, v.flg});
    chk(int'(v.req), "mask", {12'h0, upd}, {12'h0, v.upd});
    chk(int'(v.req), "wr_en", {15'h0, wr}, {15'h0, v.wr});
  endtask

  initial begin
    ctl = '0; shr_en = 0; shr_ar = 0; byt = 0; cin = 0; prev = '0; src = '0; dst = '0;
    repeat (3) @(negedge clk);
    // reset state with idle inputs: R3 write enabled, R7 nothing updated
    chk(3, "idle wr_en", {15'h0, wr}, 16'h0001);
    chk(7, "idle mask", {12'h0, upd}, 16'h0000);
    chk(7, "idle result", res, 16'h0000);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) run(TBL[i]);
    // R2 corner: 0 - 0 gives no borrow
    run('{8'd2, 12'h20B, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0000, 16'h0000, 16'h0000, 4'h3, 4'hF, 1'b1});
    // R5 R7: policy bit 8 alone keeps V from previous flags
    run('{8'd5, 12'h110, 1'b0,1'b0,1'b0,1'b0, 4'hF, 16'h000F, 16'h00F0, 16'h0000, 4'hA, 4'h7, 1'b1});
    // R1: forced increment takes precedence over carry-increment
    run('{8'd1, 12'h20E, 1'b0,1'b0,1'b0,1'b0, 4'h0, 16'h0010, 16'h0020, 16'h0031, 4'h0, 4'hF, 1'b1});
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule